// File: doc/BRIEF.md
# HDLC Transmit Framer with Split Buffer

This block turns bytes held in a 256-byte transmit store into a bit-serial HDLC line, one bit per clock. Software loads payload bytes into the store and writes the frame length into a length register. It then raises the transmit enable, either with a direct set pulse or through a hardware trigger input when trigger mode is selected. The engine starts a frame only while the enable is high and the length is non-zero. The start is taken at the next boundary of a fill byte, so the two conditions may become true in either order.

A frame goes out as a programmable number of leading flags, one opening flag, the payload, a 16-bit frame check sequence, a closing flag and a programmable number of trailing flags. A zero bit is inserted after five ones in the payload and check sequence. Outside a frame the line carries either steady ones or back-to-back flags.

The store is two 128-byte halves. Every frame reads from address 0 upward and wraps from 255 back to 0. When a half has been drained and bytes of the frame remain, the block pulses an interrupt and reports which half is now free. Software can then refill that half while the frame keeps running. At the end of a frame the enable drops by itself and a sticky done bit is set.

Top module: `hdlc_tx_framer`

## Requirements
- R1: With no frame in progress the line carries whole fill bytes: all ones when `flag_fill` is 0, and the flag 0x7E sent LSB first when it is 1. After reset the line is 1.
- R2: A frame starts only when the enable is high and the programmed length is non-zero. With the enable high and the length 0, the line stays on fill and `frame_done` is unchanged. Writing a non-zero length afterwards starts the frame.
- R3: `go_set` always sets the enable. `trig_in` sets it only while `trig_mode` is 1, and has no effect when `trig_mode` is 0.
- R4: A frame is sent in this order: `pre_flags`+1 flags, the payload bytes, the 16-bit check sequence, one closing flag, then `post_flags` flags. Both counts may be 0. Every byte goes out LSB first.
- R5: After five consecutive ones inside the payload or the check sequence, including runs that cross byte boundaries, a 0 bit is inserted. Flags and fill are never stuffed.
- R6: The check sequence is CRC-16-CCITT computed LSB first with the reversed polynomial 0x8408 and a preset of 0xFFFF. It is sent inverted, low byte first. For the payload "123456789" the sent value is 0x906E.
- R7: Each frame reads payload from store address 0 upward in address order, wrapping from 255 to 0.
- R8: When the last byte of a half (address 127 or 255) is read and bytes of the frame remain, `half_irq` pulses for one cycle. `half_empty` then becomes 0 for the low half and 1 for the high half. After reset it is 1.
- R9: When the frame ends exactly on the last byte of a half, there is no interrupt and `half_empty` is left unchanged.
- R10: In the cycle the last bit of the trailing flags (or of the closing flag, if there are none) is on the line, `frame_done` goes to 1 and the enable clears. Fill follows. `frame_done` stays 1 until the next frame starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| buf_we | input | 1 | Store write strobe |
| buf_addr | input | 8 | Store write address |
| buf_wdata | input | 8 | Store write data |
| len_we | input | 1 | Frame length write strobe |
| len_wdata | input | 12 | Frame length in bytes |
| go_set | input | 1 | Software pulse that sets the transmit enable |
| trig_in | input | 1 | Hardware trigger pulse |
| trig_mode | input | 1 | Lets `trig_in` set the enable |
| flag_fill | input | 1 | Fill type: 0 = ones, 1 = flags |
| pre_flags | input | 4 | Number of flags sent before the opening flag |
| post_flags | input | 4 | Number of flags sent after the closing flag |
| line_out | output | 1 | Serial line bit |
| tx_enable | output | 1 | Transmit enable state |
| half_empty | output | 1 | Free half: 0 = low, 1 = high |
| half_irq | output | 1 | One-cycle pulse when a half has drained mid-frame |
| frame_done | output | 1 | Sticky end-of-frame flag |

## Verification
On every cycle, the assertions check the following:
- a pending stuff bit always puts a 0 on the line, and no stuff bit appears inside flags or fill;
- fill bytes hold only one of the two fill patterns;
- the engine stays idle while the enable is low or the length is zero;
- a disabled trigger never raises the enable;
- the end-of-frame event clears the enable;
- a drained half produces exactly one interrupt with the matching half status.

Only the bench scenarios can show that the full serial stream is right. That means the flag counts, the stuffed payload, the check sequence value, the read order across the buffer wrap with a live refill, and the fill that comes before each frame. The bench compares each recorded stream with one it builds bit by bit.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;
  localparam logic [7:0]  FLAG_BYTE  = 8'h7E;
  localparam logic [7:0]  IDLE_BYTE  = 8'hFF;
  localparam logic [15:0] CRC_POLY_R = 16'h8408;
  localparam logic [15:0] CRC_PRESET = 16'hFFFF;
  localparam int          STUFF_RUN  = 5;

  typedef enum logic [2:0] {
    SEG_FILL, SEG_OPEN, SEG_DATA, SEG_FCS_LO, SEG_FCS_HI, SEG_CLOSE, SEG_POST
  } seg_e;

  // Byte-wide CRC step, LSB first, reversed polynomial.
  function automatic logic [15:0] crc16_byte(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY_R;
      else             r = r >> 1;
    end
    return r;
  endfunction

  function automatic logic is_stuffable(input seg_e s);
    return (s == SEG_DATA) || (s == SEG_FCS_LO) || (s == SEG_FCS_HI);
  endfunction
endpackage

// File: rtl/hdlc_tx_crc.sv
module hdlc_tx_crc
  import hdlc_tx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init,
  input  logic        upd,
  input  logic [7:0]  din,
  output logic [15:0] crc
);
  always_ff @(posedge clk) begin
    if (!rst_n)    crc <= CRC_PRESET;
    else if (init) crc <= CRC_PRESET;
    else if (upd)  crc <= crc16_byte(crc, din);
  end

  // R6: the running CRC only moves on a payload byte load
  a_r6_crc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!init && !upd) |=> $stable(crc));
endmodule

// File: rtl/hdlc_tx_buf.sv
module hdlc_tx_buf #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          rd_rst,
  input  logic          rd_adv,
  input  logic          more,
  output logic [7:0]    rd_data,
  output logic          half_sts,
  output logic          half_irq
);
  localparam int DEPTH = 1 << AW;

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] ptr_q;
  logic          half_drained;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data      = mem[ptr_q];
  assign half_drained = rd_adv && (ptr_q[AW-2:0] == '1) && more;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q    <= '0;
      half_sts <= 1'b1;
      half_irq <= 1'b0;
    end else begin
      half_irq <= half_drained;
      if (rd_rst)      ptr_q <= '0;
      else if (rd_adv) ptr_q <= ptr_q + 1'b1;
      if (half_drained) half_sts <= ptr_q[AW-1];
    end
  end

  // R8: a drained half gives one pulse and names the half just emptied
  a_r8_half_report: assert property (@(posedge clk) disable iff (!rst_n)
    half_drained |=> (half_irq && (half_sts == $past(ptr_q[AW-1]))));
  a_r8_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    half_irq |=> !half_irq);
endmodule

// File: rtl/hdlc_tx_framer.sv
module hdlc_tx_framer
  import hdlc_tx_pkg::*;
#(
  parameter int AW = 8,
  parameter int CW = 12,
  parameter int PW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          buf_we,
  input  logic [AW-1:0] buf_addr,
  input  logic [7:0]    buf_wdata,
  input  logic          len_we,
  input  logic [CW-1:0] len_wdata,
  input  logic          go_set,
  input  logic          trig_in,
  input  logic          trig_mode,
  input  logic          flag_fill,
  input  logic [PW-1:0] pre_flags,
  input  logic [PW-1:0] post_flags,
  output logic          line_out,
  output logic          tx_enable,
  output logic          half_empty,
  output logic          half_irq,
  output logic          frame_done
);
  seg_e          seg_q, nseg;
  logic [7:0]    sh_q, nbyte, rd_data, fill_byte;
  logic [2:0]    bit_q, ones_q;
  logic          stuff_q, cur_bit, byte_end;
  logic [PW-1:0] fcnt_q, nfcnt;
  logic [CW-1:0] cnt_q, sent_q;
  logic [15:0]   crc;
  logic          start_evt, load_evt, fin_evt;
  // named internal events
  logic          start_go, data_go, fin_go, more;

  assign fill_byte = flag_fill ? FLAG_BYTE : IDLE_BYTE;
  assign cur_bit   = sh_q[bit_q];
  assign byte_end  = !stuff_q && (bit_q == 3'd7);
  assign start_go  = byte_end && start_evt;
  assign data_go   = byte_end && load_evt;
  assign fin_go    = byte_end && fin_evt;
  assign more      = (sent_q + CW'(1)) != cnt_q;

  hdlc_tx_buf #(.AW(AW)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .wr_en(buf_we), .wr_addr(buf_addr), .wr_data(buf_wdata),
    .rd_rst(start_go), .rd_adv(data_go), .more(more),
    .rd_data(rd_data), .half_sts(half_empty), .half_irq(half_irq)
  );

  hdlc_tx_crc u_crc (
    .clk(clk), .rst_n(rst_n), .init(start_go), .upd(data_go),
    .din(rd_data), .crc(crc)
  );

  // Choice of the byte that follows the one now on the line
  always_comb begin
    nseg      = seg_q;
    nbyte     = fill_byte;
    nfcnt     = fcnt_q;
    start_evt = 1'b0;
    load_evt  = 1'b0;
    fin_evt   = 1'b0;
    unique case (seg_q)
      SEG_FILL: begin
        if (tx_enable && (cnt_q != '0)) begin
          start_evt = 1'b1;
          nseg      = SEG_OPEN;
          nbyte     = FLAG_BYTE;
          nfcnt     = pre_flags;
        end
      end
      SEG_OPEN: begin
        if (fcnt_q != '0) begin
          nbyte = FLAG_BYTE;
          nfcnt = fcnt_q - PW'(1);
        end else begin
          nseg     = SEG_DATA;
          nbyte    = rd_data;
          load_evt = 1'b1;
        end
      end
      SEG_DATA: begin
        if (sent_q == cnt_q) begin
          nseg  = SEG_FCS_LO;
          nbyte = ~crc[7:0];
        end else begin
          nbyte    = rd_data;
          load_evt = 1'b1;
        end
      end
      SEG_FCS_LO: begin
        nseg  = SEG_FCS_HI;
        nbyte = ~crc[15:8];
      end
      SEG_FCS_HI: begin
        nseg  = SEG_CLOSE;
        nbyte = FLAG_BYTE;
      end
      SEG_CLOSE: begin
        if (post_flags != '0) begin
          nseg  = SEG_POST;
          nbyte = FLAG_BYTE;
          nfcnt = post_flags - PW'(1);
        end else begin
          nseg    = SEG_FILL;
          fin_evt = 1'b1;
        end
      end
      SEG_POST: begin
        if (fcnt_q != '0) begin
          nbyte = FLAG_BYTE;
          nfcnt = fcnt_q - PW'(1);
        end else begin
          nseg    = SEG_FILL;
          fin_evt = 1'b1;
        end
      end
      default: nseg = SEG_FILL;
    endcase
  end

  // Serializer with zero insertion
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seg_q    <= SEG_FILL;
      sh_q     <= IDLE_BYTE;
      bit_q    <= '0;
      ones_q   <= '0;
      stuff_q  <= 1'b0;
      fcnt_q   <= '0;
      line_out <= 1'b1;
    end else if (stuff_q) begin
      line_out <= 1'b0;
      stuff_q  <= 1'b0;
      ones_q   <= '0;
    end else begin
      line_out <= cur_bit;
      if (is_stuffable(seg_q) && cur_bit) begin
        if (ones_q == 3'(STUFF_RUN - 1)) begin
          stuff_q <= 1'b1;
          ones_q  <= '0;
        end else begin
          ones_q <= ones_q + 3'd1;
        end
      end else begin
        ones_q <= '0;
      end
      bit_q <= bit_q + 3'd1;
      if (bit_q == 3'd7) begin
        seg_q  <= nseg;
        sh_q   <= nbyte;
        fcnt_q <= nfcnt;
      end
    end
  end

  // Control registers and counters
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      sent_q     <= '0;
      tx_enable  <= 1'b0;
      frame_done <= 1'b0;
    end else begin
      if (len_we) cnt_q <= len_wdata;
      if (start_go)     sent_q <= '0;
      else if (data_go) sent_q <= sent_q + CW'(1);
      if (go_set || (trig_mode && trig_in)) tx_enable <= 1'b1;
      else if (fin_go)                      tx_enable <= 1'b0;
      if (fin_go)        frame_done <= 1'b1;
      else if (start_go) frame_done <= 1'b0;
    end
  end

  // R1: fill bytes are only ones or flags
  a_r1_fill_pattern: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_q == SEG_FILL) |-> ((sh_q == IDLE_BYTE) || (sh_q == FLAG_BYTE)));
  // R2: no start without enable and a non-zero length
  a_r2_hold_fill: assert property (@(posedge clk) disable iff (!rst_n)
    ((seg_q == SEG_FILL) && (!tx_enable || (cnt_q == '0))) |=> (seg_q == SEG_FILL));
  // R3: trigger ignored when trigger mode is off
  a_r3_trig_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_enable && !go_set && !trig_mode) |=> !tx_enable);
  // R4: the closing flag follows the check sequence
  a_r4_close_after_fcs: assert property (@(posedge clk) disable iff (!rst_n)
    ((seg_q == SEG_FCS_HI) && byte_end) |=> (seg_q == SEG_CLOSE));
  // R5: an inserted bit is a zero on the line
  a_r5_stuff_zero: assert property (@(posedge clk) disable iff (!rst_n)
    stuff_q |=> !line_out);
  // R5: no insertion inside flags or fill
  a_r5_no_stuff_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_stuffable(seg_q) && (bit_q != 3'd0)) |-> !stuff_q);
  // R10: end of frame drops the enable and sets done
  a_r10_end_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_go && !go_set && !(trig_mode && trig_in)) |=> (!tx_enable && frame_done));
endmodule

// File: tb/hdlc_tx_framer_tb.sv
module hdlc_tx_framer_tb;
  localparam int AW = 8;
  localparam int CW = 12;
  localparam int PW = 4;
  localparam logic [7:0] FLAGV = 8'h7E;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          buf_we = 1'b0;
  logic [AW-1:0] buf_addr = '0;
  logic [7:0]    buf_wdata = '0;
  logic          len_we = 1'b0;
  logic [CW-1:0] len_wdata = '0;
  logic          go_set = 1'b0, trig_in = 1'b0, trig_mode = 1'b0, flag_fill = 1'b0;
  logic [PW-1:0] pre_flags = '0, post_flags = '0;
  logic          line_out, tx_enable, half_empty, half_irq, frame_done;

  hdlc_tx_framer #(.AW(AW), .CW(CW), .PW(PW)) u_dut (
    .clk(clk), .rst_n(rst_n), .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
    .len_we(len_we), .len_wdata(len_wdata), .go_set(go_set), .trig_in(trig_in),
    .trig_mode(trig_mode), .flag_fill(flag_fill), .pre_flags(pre_flags),
    .post_flags(post_flags), .line_out(line_out), .tx_enable(tx_enable),
    .half_empty(half_empty), .half_irq(half_irq), .frame_done(frame_done)
  );

  always #10 clk = ~clk;

  int   checks = 0, fails = 0;
  bit   finished = 0;
  logic [7:0] payload [512];
  bit   exp_q[$];
  bit   rec_q[$];
  bit   rec_done, timed_out;
  int   irq_seen;
  logic exp_half;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // Bit-serial restatement of the check sequence
  function automatic logic [15:0] fcs_of(input int n);
    logic [15:0] c;
    c = 16'hFFFF;
    for (int k = 0; k < n; k++)
      for (int i = 0; i < 8; i++) begin
        if (c[0] ^ payload[k][i]) c = {1'b0, c[15:1]} ^ 16'h8408;
        else                      c = {1'b0, c[15:1]};
      end
    return ~c;
  endfunction

  task automatic push_flag();
    for (int i = 0; i < 8; i++) exp_q.push_back(FLAGV[i]);
  endtask

  task automatic build_expected(input int n, input int pre, input int post, input logic [15:0] fcs);
    int run;
    exp_q.delete();
    run = 0;
    for (int f = 0; f <= pre; f++) push_flag();
    for (int k = 0; k < n + 2; k++)
      for (int i = 0; i < 8; i++) begin
        bit b;
        if (k < n) b = payload[k][i];
        else       b = fcs[(k - n) * 8 + i];
        exp_q.push_back(b);
        if (b) run++; else run = 0;
        if (run == 5) begin exp_q.push_back(1'b0); run = 0; end
      end
    push_flag();
    for (int f = 0; f < post; f++) push_flag();
  endtask

  // mode 0: go pulse, 1: hardware trigger, 2: enable first, length last
  task automatic run_frame(input int n, input int pre, input int post, input bit ffill,
                           input int mode, input bit fixed, input logic [15:0] fval);
    logic [15:0] fcs;
    int nrec, m, base, bad;
    bit ok;
    @(negedge clk);
    flag_fill = ffill; pre_flags = PW'(pre); post_flags = PW'(post);
    trig_mode = (mode == 1);
    for (int k = 0; k < n && k < 256; k++) begin
      buf_we = 1'b1; buf_addr = AW'(k); buf_wdata = payload[k];
      @(negedge clk);
    end
    buf_we = 1'b0;
    len_we = 1'b1; len_wdata = (mode == 2) ? '0 : CW'(n);
    @(negedge clk);
    len_we = 1'b0;
    repeat (20) @(negedge clk);
    rec_q.delete(); irq_seen = 0; rec_done = 0; timed_out = 0;
    if (mode == 1) trig_in = 1'b1; else go_set = 1'b1;
    @(negedge clk);
    trig_in = 1'b0; go_set = 1'b0;
    if (mode == 2) begin
      ok = 1;
      for (int c = 0; c < 40; c++) begin
        if (line_out !== 1'b1) ok = 0;
        @(negedge clk);
      end
      chk(ok, "R2", "line held on fill with zero length", 0, 1);
      chk(tx_enable === 1'b1 && frame_done === 1'b1, "R2", "enable high, done untouched",
          {tx_enable, frame_done}, 3);
      len_we = 1'b1; len_wdata = CW'(n);
      @(negedge clk);
      len_we = 1'b0;
    end
    fork
      begin
        bit seen_low;
        int cyc;
        seen_low = 0; cyc = 0;
        forever begin
          rec_q.push_back(line_out);
          if (half_irq) irq_seen++;
          if (!frame_done) seen_low = 1;
          else if (seen_low) break;
          cyc++;
          if (cyc > 30000) begin timed_out = 1; break; end
          @(negedge clk);
        end
        rec_done = 1;
      end
      begin
        if (n > 256) begin
          while (half_empty !== 1'b0 && !rec_done) @(negedge clk);
          for (int k = 0; k < n - 256 && k < 128; k++) begin
            buf_we = 1'b1; buf_addr = AW'(k); buf_wdata = payload[256 + k];
            @(negedge clk);
          end
          buf_we = 1'b0;
        end
      end
    join
    chk(!timed_out, "R10", "frame completed", timed_out, 0);
    fcs = fixed ? fval : fcs_of(n);
    build_expected(n, pre, post, fcs);
    nrec = rec_q.size(); m = exp_q.size(); base = nrec - m;
    bad = -1;
    if (base >= 0)
      for (int i = 0; i < m; i++)
        if (bad < 0 && rec_q[base + i] != exp_q[i]) bad = i;
    chk(base >= 0 && bad < 0, "R4 R5 R6 R7", "frame bits (first mismatch index)", bad, -1);
    ok = 1;
    for (int j = 0; j < base; j++) begin
      bit e;
      e = ffill ? FLAGV[7 - (j % 8)] : 1'b1;
      if (rec_q[base - 1 - j] != e) ok = 0;
    end
    chk(ok, "R1", "fill before frame", ok, 1);
    chk(tx_enable === 1'b0, "R10", "enable cleared at end", tx_enable, 0);
    chk(frame_done === 1'b1, "R10", "done set at end", frame_done, 1);
    if ((n - 1) / 128 > 0) exp_half = (((n - 1) / 128) % 2 == 0);
    chk(irq_seen == (n - 1) / 128, "R8 R9", "half interrupts", irq_seen, (n - 1) / 128);
    chk(half_empty === exp_half, "R8 R9", "half status", half_empty, exp_half);
    trig_mode = 1'b0;
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R10 watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    bit ok, any;
    void'($urandom(32'd20240611));
    exp_half = 1'b1;
    repeat (5) @(negedge clk);
    chk(line_out === 1'b1, "R1", "line in reset", line_out, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tx_enable === 1'b0, "R10", "enable after reset", tx_enable, 0);
    chk(half_empty === 1'b1, "R8", "half status after reset", half_empty, 1);
    chk(half_irq === 1'b0 && frame_done === 1'b0, "R8 R10", "irq and done after reset",
        {half_irq, frame_done}, 0);
    // R1: idle fill
    ok = 1;
    for (int c = 0; c < 24; c++) begin
      if (line_out !== 1'b1) ok = 0;
      @(negedge clk);
    end
    chk(ok, "R1", "idle ones fill", ok, 1);
    // R1: flag fill periodic pattern
    flag_fill = 1'b1;
    repeat (20) @(negedge clk);
    rec_q.delete();
    for (int c = 0; c < 32; c++) begin rec_q.push_back(line_out); @(negedge clk); end
    any = 0;
    for (int ph = 0; ph < 8; ph++) begin
      ok = 1;
      for (int i = 0; i < 32; i++) if (rec_q[i] != FLAGV[(i + ph) % 8]) ok = 0;
      if (ok) any = 1;
    end
    chk(any, "R1", "flag fill pattern", any, 1);
    flag_fill = 1'b0;
    // R3: trigger ignored while trigger mode is off
    trig_mode = 1'b0; trig_in = 1'b1;
    @(negedge clk);
    trig_in = 1'b0;
    @(negedge clk);
    chk(tx_enable === 1'b0, "R3", "trigger without trigger mode", tx_enable, 0);

    // R6: known check value
    for (int k = 0; k < 9; k++) payload[k] = 8'h31 + 8'(k);
    run_frame(9, 0, 0, 1'b0, 0, 1'b1, 16'h906E);
    // R7 R8: long frame wrapping the store, refilled during transmission
    for (int k = 0; k < 300; k++) payload[k] = 8'($urandom);
    run_frame(300, 1, 1, 1'b0, 0, 1'b0, 16'h0);
    // R3 R5 R8: all ones, flag fill, hardware trigger, one interrupt
    for (int k = 0; k < 129; k++) payload[k] = 8'hFF;
    run_frame(129, 2, 0, 1'b1, 1, 1'b0, 16'h0);
    // R2 R9: exact half, length written last
    for (int k = 0; k < 128; k++) payload[k] = 8'($urandom);
    run_frame(128, 0, 2, 1'b0, 2, 1'b0, 16'h0);
    // random frames
    for (int f = 0; f < 6; f++) begin
      int n;
      n = (f == 0) ? 1 : 1 + int'($urandom % 60);
      for (int k = 0; k < n; k++) payload[k] = ($urandom % 2) ? 8'hFF : 8'($urandom);
      run_frame(n, int'($urandom % 4), int'($urandom % 4), 1'($urandom % 2), 0, 1'b0, 16'h0);
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule